// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Unit

This block holds a small bank of address-comparison triggers that sit beside a processor pipeline. Each cycle it sees the program counter of an instruction fetch and the address of a load or store, together with the privilege level the hart runs at. When an enabled trigger's comparison succeeds for an access kind it is set to watch, the unit raises, one clock later, either a breakpoint-exception request or a debug-entry request, tagged with the number of the trigger responsible.

Software sets the triggers up through a CSR-style port with three locations: a select register, a configuration word for the selected trigger, and a 64-bit match value for the selected trigger. A configuration word carries a type nibble, privilege enables, access-kind selects, a comparison mode, an action bit and a chain bit. A chained trigger joins its higher-numbered neighbour, so that a pair only fires when both compare true on the same cycle, which lets a fetch address and a store address be watched together.

Top module: `trig_unit`

## Requirements
- R1: After reset the select register reads 0, every configuration word and match value reads 0, and neither request output is high.
- R2: A write to location 0 with a value below the trigger count (2) sets the select register; a write of 2 or more leaves it unchanged. Locations 1 and 2 read and write the selected trigger; location 3 reads 0.
- R3: A configuration write whose bits 63:60 equal 2 is kept, reading back only bits 63:60, 12:6 and 4:0 (all other bits read 0); a write with any other type value stores all zeros and the trigger never fires.
- R4: Configuration bit 2 arms a trigger on fetches (fetch_pc when fetch_valid), bit 1 on stores and bit 0 on loads (ls_addr when ls_valid, ls_is_store telling store 1 from load 0).
- R5: A trigger compares only while its privilege enable is set: bit 6 for machine (priv 3), bit 4 for supervisor (priv 1), bit 3 for user (priv 0); priv 2 never matches.
- R6: Bits 10:7 pick the comparison against the match value T: 0 equal, 1 masked (the trailing ones of T are ignored, all other bits must equal), 2 address unsigned greater-or-equal T, 3 address unsigned less than T; any other code never matches.
- R7: Bit 12 picks the response: 0 gives brk_req, 1 gives dbg_req, one clock after the matching access, with fire_idx naming the trigger; at most one request is high per cycle, and no match gives no request.
- R8: With bit 11 set on trigger 0, neither trigger 0 nor trigger 1 fires unless both match in the same cycle; the pair then uses trigger 1's action and reports index 1. Bit 11 on the last trigger has no effect.
- R9: When several triggers fire in a cycle, the lowest-numbered one is reported with its own action.
- R10: While in_debug is high no request is raised in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_we | input | 1 | Write strobe for the CSR port |
| csr_addr | input | 2 | 0 select, 1 configuration, 2 match value |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for csr_addr (combinational) |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | 64 | Fetch address |
| ls_valid | input | 1 | A load or store is presented this cycle |
| ls_is_store | input | 1 | 1 store, 0 load |
| ls_addr | input | 64 | Load/store address |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| in_debug | input | 1 | Hart already in debug mode |
| dbg_req | output | 1 | Debug-entry request (registered) |
| brk_req | output | 1 | Breakpoint-exception request (registered) |
| fire_idx | output | 1 | Trigger number behind the current request |

## Verification
The bench aims at the boundaries of each comparison mode (the address equal to the match value for greater-or-equal and less-than, the first address past a masked region), where an off-by-one comparator would fire one address early or late. It drives a chained pair with only one half matching, which a design that ignored the chain bit would report, and with both matching, where taking the first trigger's action would raise the wrong request. It also writes a foreign type value and an out-of-range select; a design that kept them would either fire an inert trigger or point configuration writes at a trigger that does not exist.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int CFG_W      = 64;
  localparam int TYPE_LSB   = 60;
  localparam logic [3:0] TYPE_ADDR = 4'd2;

  localparam int B_LOAD   = 0;
  localparam int B_STORE  = 1;
  localparam int B_EXEC   = 2;
  localparam int B_UMODE  = 3;
  localparam int B_SMODE  = 4;
  localparam int B_MMODE  = 6;
  localparam int B_MODE   = 7;
  localparam int B_CHAIN  = 11;
  localparam int B_ACTION = 12;

  typedef enum logic [3:0] {
    CMP_EQ    = 4'd0,
    CMP_NAPOT = 4'd1,
    CMP_GE    = 4'd2,
    CMP_LT    = 4'd3
  } cmp_e;

  typedef enum logic [1:0] {
    PRV_U = 2'd0,
    PRV_S = 2'd1,
    PRV_H = 2'd2,
    PRV_M = 2'd3
  } prv_e;

  typedef struct packed {
    logic       valid;
    logic       action;
    logic       chain;
    logic [3:0] mode;
    logic       en_m;
    logic       en_s;
    logic       en_u;
    logic       on_exec;
    logic       on_store;
    logic       on_load;
  } trig_cfg_t;

  function automatic trig_cfg_t cfg_unpack(logic [CFG_W-1:0] w);
    trig_cfg_t c;
    c.valid    = (w[CFG_W-1:TYPE_LSB] == TYPE_ADDR);
    c.action   = w[B_ACTION];
    c.chain    = w[B_CHAIN];
    c.mode     = w[B_MODE+3:B_MODE];
    c.en_m     = w[B_MMODE];
    c.en_s     = w[B_SMODE];
    c.en_u     = w[B_UMODE];
    c.on_exec  = w[B_EXEC];
    c.on_store = w[B_STORE];
    c.on_load  = w[B_LOAD];
    if (!c.valid) c = '0;
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(trig_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    if (c.valid) begin
      w[CFG_W-1:TYPE_LSB]  = TYPE_ADDR;
      w[B_ACTION]          = c.action;
      w[B_CHAIN]           = c.chain;
      w[B_MODE+3:B_MODE]   = c.mode;
      w[B_MMODE]           = c.en_m;
      w[B_SMODE]           = c.en_s;
      w[B_UMODE]           = c.en_u;
      w[B_EXEC]            = c.on_exec;
      w[B_STORE]           = c.on_store;
      w[B_LOAD]            = c.on_load;
    end
    return w;
  endfunction

endpackage

// File: rtl/trig_regs.sv
module trig_regs
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 2,
  parameter int AW       = 64,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          csr_we,
  input  logic [1:0]                    csr_addr,
  input  logic [CFG_W-1:0]              csr_wdata,
  output logic [CFG_W-1:0]              csr_rdata,
  output trig_cfg_t [NUM_TRIG-1:0]      cfg,
  output logic [NUM_TRIG-1:0][AW-1:0]   tval
);

  localparam logic [1:0] A_SEL = 2'd0;
  localparam logic [1:0] A_CFG = 2'd1;
  localparam logic [1:0] A_VAL = 2'd2;

  logic [IDX_W-1:0] sel;
  logic             sel_ok;

  assign sel_ok = (csr_wdata < CFG_W'(NUM_TRIG));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (csr_we && csr_addr == A_SEL && sel_ok) begin
      sel <= csr_wdata[IDX_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[g]  <= '0;
        tval[g] <= '0;
      end else if (csr_we && sel == IDX_W'(g)) begin
        if (csr_addr == A_CFG) cfg[g]  <= cfg_unpack(csr_wdata);
        if (csr_addr == A_VAL) tval[g] <= csr_wdata[AW-1:0];
      end
    end
  end

  always_comb begin
    unique case (csr_addr)
      A_SEL:   csr_rdata = CFG_W'(sel);
      A_CFG:   csr_rdata = cfg_pack(cfg[sel]);
      A_VAL:   csr_rdata = CFG_W'(tval[sel]);
      default: csr_rdata = '0;
    endcase
  end

  // R2: an out-of-range select write leaves the select register alone
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_addr == A_SEL && csr_wdata >= CFG_W'(NUM_TRIG)) |=> $stable(sel));

endmodule

// File: rtl/trig_match.sv
module trig_match
  import trig_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  trig_cfg_t  cfg,
  input  logic [AW-1:0] tval,
  input  logic       fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic       ls_valid,
  input  logic       ls_is_store,
  input  logic [AW-1:0] ls_addr,
  input  logic [1:0] priv,
  output logic       hit
);

  logic [AW-1:0] care;
  logic          prv_ok;
  logic          cmp_pc;
  logic          cmp_ls;

  // trailing ones of the match value are don't-care bits
  assign care = ~((tval ^ (tval + AW'(1))) >> 1);

  function automatic logic addr_cmp(logic [3:0] mode, logic [AW-1:0] a,
                                    logic [AW-1:0] t, logic [AW-1:0] m);
    logic r;
    case (mode)
      CMP_EQ:    r = (a == t);
      CMP_NAPOT: r = ((a & m) == (t & m));
      CMP_GE:    r = (a >= t);
      CMP_LT:    r = (a < t);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  always_comb begin
    case (priv)
      PRV_M:   prv_ok = cfg.en_m;
      PRV_S:   prv_ok = cfg.en_s;
      PRV_U:   prv_ok = cfg.en_u;
      default: prv_ok = 1'b0;
    endcase
  end

  assign cmp_pc = addr_cmp(cfg.mode, fetch_pc, tval, care);
  assign cmp_ls = addr_cmp(cfg.mode, ls_addr, tval, care);

  assign hit = cfg.valid && prv_ok &&
               ((cfg.on_exec  && fetch_valid && cmp_pc) ||
                (cfg.on_load  && ls_valid && !ls_is_store && cmp_ls) ||
                (cfg.on_store && ls_valid &&  ls_is_store && cmp_ls));

  // R5: the reserved privilege level never produces a hit
  p_priv2_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (priv == PRV_H) |-> !hit);

endmodule

// File: rtl/trig_arbiter.sv
module trig_arbiter #(
  parameter int NUM_TRIG = 2,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIG-1:0] hit,
  input  logic [NUM_TRIG-1:0] chain,
  input  logic [NUM_TRIG-1:0] action,
  input  logic                in_debug,
  output logic                dbg_req,
  output logic                brk_req,
  output logic [IDX_W-1:0]    fire_idx
);

  logic [NUM_TRIG-1:0] fire;
  logic                found;
  logic                win_act;
  logic [IDX_W-1:0]    win_idx;

  // a chain group fires at its last member when every member hit
  always_comb begin
    logic prev_link;
    logic prev_ok;
    logic cur_ok;
    logic last;
    prev_link = 1'b0;
    prev_ok   = 1'b0;
    fire      = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      last      = (i == NUM_TRIG - 1);
      cur_ok    = hit[i] && (!prev_link || prev_ok);
      fire[i]   = cur_ok && (last || !chain[i]);
      prev_link = chain[i] && !last;
      prev_ok   = cur_ok;
    end
  end

  always_comb begin
    found   = 1'b0;
    win_act = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (fire[i] && !found) begin
        found   = 1'b1;
        win_act = action[i];
        win_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_req  <= 1'b0;
      brk_req  <= 1'b0;
      fire_idx <= '0;
    end else begin
      dbg_req  <= found && !in_debug &&  win_act;
      brk_req  <= found && !in_debug && !win_act;
      fire_idx <= found ? win_idx : '0;
    end
  end

  // R7: the two requests are never raised together
  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(dbg_req && brk_req));

  // R7: no trigger hit means no request in the next cycle
  p_no_hit_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |=> (!dbg_req && !brk_req));

  // R10: nothing fires for an access seen while in debug mode
  p_debug_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    in_debug |=> (!dbg_req && !brk_req));

endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 2,
  parameter int AW       = 64,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [1:0]        csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  input  logic              fetch_valid,
  input  logic [AW-1:0]     fetch_pc,
  input  logic              ls_valid,
  input  logic              ls_is_store,
  input  logic [AW-1:0]     ls_addr,
  input  logic [1:0]        priv,
  input  logic              in_debug,
  output logic              dbg_req,
  output logic              brk_req,
  output logic [IDX_W-1:0]  fire_idx
);

  trig_cfg_t [NUM_TRIG-1:0]    cfg;
  logic [NUM_TRIG-1:0][AW-1:0] tval;
  logic [NUM_TRIG-1:0]         hit;
  logic [NUM_TRIG-1:0]         chain;
  logic [NUM_TRIG-1:0]         action;

  trig_regs #(.NUM_TRIG(NUM_TRIG), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .cfg       (cfg),
    .tval      (tval)
  );

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    trig_match #(.AW(AW)) u_match (
      .clk         (clk),
      .rst         (rst),
      .cfg         (cfg[g]),
      .tval        (tval[g]),
      .fetch_valid (fetch_valid),
      .fetch_pc    (fetch_pc),
      .ls_valid    (ls_valid),
      .ls_is_store (ls_is_store),
      .ls_addr     (ls_addr),
      .priv        (priv),
      .hit         (hit[g])
    );
    assign chain[g]  = cfg[g].chain;
    assign action[g] = cfg[g].action;
  end

  trig_arbiter #(.NUM_TRIG(NUM_TRIG)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .chain    (chain),
    .action   (action),
    .in_debug (in_debug),
    .dbg_req  (dbg_req),
    .brk_req  (brk_req),
    .fire_idx (fire_idx)
  );

endmodule

// File: tb/sim_trig_unit.sv
module sim_trig_unit;

  localparam int PERIOD = 10;
  localparam int NT     = 2;
  localparam logic [63:0] KEEP = 64'hF000_0000_0000_1FDF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        fetch_valid = 1'b0;
  logic [63:0] fetch_pc = '0;
  logic        ls_valid = 1'b0;
  logic        ls_is_store = 1'b0;
  logic [63:0] ls_addr = '0;
  logic [1:0]  priv = 2'd3;
  logic        in_debug = 1'b0;
  logic        dbg_req;
  logic        brk_req;
  logic [0:0]  fire_idx;

  int checks = 0;
  int fails  = 0;

  logic [63:0] m_cfg [NT];
  logic [63:0] m_tval[NT];
  int          m_sel;

  always #(PERIOD/2) clk = ~clk;

  trig_unit u0 (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .ls_valid(ls_valid),
    .ls_is_store(ls_is_store), .ls_addr(ls_addr), .priv(priv),
    .in_debug(in_debug), .dbg_req(dbg_req), .brk_req(brk_req),
    .fire_idx(fire_idx)
  );

  function automatic logic [63:0] cw(bit act, bit chn, int mode, bit m, bit s,
                                     bit u, bit x, bit st, bit ld);
    logic [63:0] w = '0;
    w[63:60] = 4'd2; w[12] = act; w[11] = chn; w[10:7] = 4'(mode);
    w[6] = m; w[4] = s; w[3] = u; w[2] = x; w[1] = st; w[0] = ld;
    return w;
  endfunction

  function automatic bit addr_ok(int i, logic [63:0] a);
    logic [63:0] t = m_tval[i];
    int ones = 0;
    case (int'(m_cfg[i][10:7]))
      0: return a == t;
      1: begin
        while (ones < 63 && t[ones]) ones++;
        return (a >> ones) == (t >> ones);
      end
      2: return a >= t;
      3: return a < t;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_hit(int i);
    logic [63:0] c = m_cfg[i];
    bit pe;
    if (c[63:60] != 4'd2) return 0;
    pe = (priv == 2'd3) ? c[6] : (priv == 2'd1) ? c[4] : (priv == 2'd0) ? c[3] : 1'b0;
    if (!pe) return 0;
    if (c[2] && fetch_valid && addr_ok(i, fetch_pc)) return 1;
    if (c[0] && ls_valid && !ls_is_store && addr_ok(i, ls_addr)) return 1;
    if (c[1] && ls_valid && ls_is_store && addr_ok(i, ls_addr)) return 1;
    return 0;
  endfunction

  // expected {dbg, brk, idx} for the inputs now on the pins
  task automatic predict(output bit e_dbg, output bit e_brk, output int e_idx);
    int s = 0;
    e_dbg = 0; e_brk = 0; e_idx = 0;
    if (in_debug) return;
    while (s < NT) begin
      int j = s;
      bit all = 1;
      while (j < NT - 1 && m_cfg[j][11]) j++;
      for (int k = s; k <= j; k++) if (!m_hit(k)) all = 0;
      if (all) begin
        e_idx = j;
        if (m_cfg[j][12]) e_dbg = 1; else e_brk = 1;
        return;
      end
      s = j + 1;
    end
  endtask

  task automatic clock_and_check(string req);
    bit e_dbg, e_brk;
    int e_idx;
    predict(e_dbg, e_brk, e_idx);
    @(posedge clk);
    if (csr_we && !rst) begin
      if (csr_addr == 2'd0 && csr_wdata < 64'(NT)) m_sel = int'(csr_wdata);
      if (csr_addr == 2'd1) m_cfg[m_sel] = (csr_wdata[63:60] == 4'd2) ? (csr_wdata & KEEP) : '0;
      if (csr_addr == 2'd2) m_tval[m_sel] = csr_wdata;
    end
    @(negedge clk);
    checks++;
    if (dbg_req !== e_dbg || brk_req !== e_brk ||
        ((e_dbg || e_brk) && int'(fire_idx) != e_idx)) begin
      fails++;
      $display("FAIL %s: dbg=%0d brk=%0d idx=%0d expected dbg=%0d brk=%0d idx=%0d",
               req, dbg_req, brk_req, fire_idx, e_dbg, e_brk, e_idx);
    end
    csr_we = 0; fetch_valid = 0; ls_valid = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [63:0] d);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    clock_and_check("R7 csr write cycle");
  endtask

  task automatic rd(logic [1:0] a, string req);
    logic [63:0] exp;
    csr_addr = a;
    #1;
    exp = (a == 2'd0) ? 64'(m_sel) : (a == 2'd1) ? m_cfg[m_sel] :
          (a == 2'd2) ? m_tval[m_sel] : 64'd0;
    checks++;
    if (csr_rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected %h", req, csr_rdata, exp);
    end
  endtask

  task automatic fetch(logic [63:0] pc, logic [1:0] p, string req);
    fetch_valid = 1; fetch_pc = pc; priv = p;
    clock_and_check(req);
  endtask

  task automatic mem(logic [63:0] a, bit st, logic [1:0] p, string req);
    ls_valid = 1; ls_addr = a; ls_is_store = st; priv = p;
    clock_and_check(req);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) begin m_cfg[i] = '0; m_tval[i] = '0; end
    m_sel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    clock_and_check("R1 idle after reset");
    rd(2'd0, "R1 select");
    rd(2'd1, "R1 cfg0");
    rd(2'd2, "R1 tval0");
    // R2 select handling
    wr(2'd0, 64'd1);  rd(2'd0, "R2 select 1");
    rd(2'd1, "R1 cfg1");
    wr(2'd0, 64'd2);  rd(2'd0, "R2 select 2 ignored");
    wr(2'd0, 64'hFFFF_0000_0000_0000); rd(2'd0, "R2 large select ignored");
    rd(2'd3, "R2 location 3");
    wr(2'd0, 64'd0);  rd(2'd0, "R2 select 0");
    // R3 config readback with stray bits
    wr(2'd1, cw(0,0,0,1,0,0,1,0,0) | 64'h0000_0010_0010_0020);
    rd(2'd1, "R3 cfg masked readback");
    wr(2'd2, 64'h8000_0100); rd(2'd2, "R2 tval write");
    // R4 / R7 fetch breakpoint
    fetch(64'h8000_0100, 2'd3, "R7 fetch brk idx0");
    fetch(64'h8000_0104, 2'd3, "R4 fetch mismatch");
    mem(64'h8000_0100, 0, 2'd3, "R4 load ignored by exec trigger");
    mem(64'h8000_0100, 1, 2'd3, "R4 store ignored by exec trigger");
    // R5 privilege
    fetch(64'h8000_0100, 2'd1, "R5 supervisor disabled");
    fetch(64'h8000_0100, 2'd0, "R5 user disabled");
    fetch(64'h8000_0100, 2'd2, "R5 priv 2");
    // loads/stores, S and U, debug action
    wr(2'd1, cw(1,0,0,0,1,1,0,1,1));
    mem(64'h8000_0100, 0, 2'd0, "R4 load user dbg");
    mem(64'h8000_0100, 1, 2'd1, "R4 store supervisor dbg");
    mem(64'h8000_0100, 1, 2'd3, "R5 machine disabled");
    fetch(64'h8000_0100, 2'd0, "R4 fetch not armed");
    // R6 modes
    wr(2'd2, 64'h1000);
    wr(2'd1, cw(0,0,2,1,0,0,0,1,0));
    mem(64'h1000, 1, 2'd3, "R6 ge equal");
    mem(64'h0FFF, 1, 2'd3, "R6 ge below");
    wr(2'd1, cw(0,0,3,1,0,0,0,1,0));
    mem(64'h0FFF, 1, 2'd3, "R6 lt below");
    mem(64'h1000, 1, 2'd3, "R6 lt equal");
    wr(2'd2, 64'h20FF);
    wr(2'd1, cw(0,0,1,1,0,0,0,1,0));
    mem(64'h2000, 1, 2'd3, "R6 napot low");
    mem(64'h20FF, 1, 2'd3, "R6 napot high");
    mem(64'h2100, 1, 2'd3, "R6 napot past");
    mem(64'h1F00, 1, 2'd3, "R6 napot before");
    wr(2'd1, cw(0,0,5,1,0,0,0,1,0));
    mem(64'h20FF, 1, 2'd3, "R6 reserved mode");
    // R3 foreign type
    wr(2'd1, cw(0,0,0,1,1,1,1,1,1) ^ 64'h1000_0000_0000_0000);
    rd(2'd1, "R3 foreign type zero");
    wr(2'd2, 64'h8000_0100);
    fetch(64'h8000_0100, 2'd3, "R3 foreign type inert");
    // R9 priority
    wr(2'd1, cw(0,0,0,1,0,0,1,0,0));
    wr(2'd0, 64'd1);
    wr(2'd2, 64'h8000_0100);
    wr(2'd1, cw(1,0,0,1,0,0,1,0,0));
    fetch(64'h8000_0100, 2'd3, "R9 lowest wins");
    // R8 chain
    wr(2'd2, 64'h9000);
    wr(2'd1, cw(1,0,0,1,0,0,0,1,0));
    wr(2'd0, 64'd0);
    wr(2'd1, cw(0,1,0,1,0,0,1,0,0));
    fetch(64'h8000_0100, 2'd3, "R8 chain first half only");
    mem(64'h9000, 1, 2'd3, "R8 chain second half only");
    fetch_valid = 1; fetch_pc = 64'h8000_0100;
    mem(64'h9000, 1, 2'd3, "R8 chain both");
    // R8 chain bit on last trigger
    wr(2'd1, cw(0,0,0,1,0,0,1,0,0));
    wr(2'd0, 64'd1);
    wr(2'd1, cw(1,1,0,1,0,0,0,1,0));
    mem(64'h9000, 1, 2'd3, "R8 last chain ignored");
    // R10 debug mode
    in_debug = 1;
    fetch_valid = 1; fetch_pc = 64'h8000_0100;
    mem(64'h9000, 1, 2'd3, "R10 in debug");
    in_debug = 0;
    fetch(64'h8000_0100, 2'd3, "R7 after debug");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule